// File: doc/BRIEF.md
# Audio Codec Programmed-I/O Status Sequencer

This block is the host-side status logic for programmed-I/O transfers in a stereo audio codec. It tracks which byte and channel the playback path wants next and which byte and channel the capture path holds next. It raises a ready flag for each path and reports a combined slip flag when a sample period ends before the host has serviced the whole sample. It also keeps one sticky interrupt bit, set by a DMA count underflow and gated onto an interrupt pin.

The host talks to the block over an 8-bit register port with a 2-bit address. A status byte is returned at address 2. Accesses to address 3, the sample data port, advance the sequencers: a write advances playback and a read advances capture. Sample-tick strobes from the converter side and the underflow strobe from the DMA side can arrive from another clock domain. Each passes through a synchronizer and a rising-edge detector before it acts. A status read captures the byte once, at the clock edge of the read. A bit that changes during the access is therefore seen on the next read.

Each path runs one state machine with the states LEFT_LO, LEFT_HI, RIGHT_LO, RIGHT_HI and IDLE. A sample tick moves the machine from any state to its first state, which is LEFT_LO in 16-bit mode and LEFT_HI in 8-bit mode. A data access moves it one step: LEFT_LO→LEFT_HI. LEFT_HI goes to RIGHT_LO (16-bit stereo), to RIGHT_HI (8-bit stereo) or to IDLE (mono). RIGHT_LO→RIGHT_HI, and RIGHT_HI→IDLE. IDLE means no byte is pending, and IDLE stays in IDLE on a data access.

Top module: `codec_pio_status`

## Requirements
- R1: After reset, a read of address 2 returns 8'hCC and the interrupt pin is low.
- R2: The status byte holds, from bit 7 to bit 0: capture upper, capture left, capture ready, slip, playback upper, playback left, playback ready, interrupt. A left bit of 1 means left channel or mono, and 0 means right. An upper bit of 1 means upper byte or 8-bit mode, and 0 means lower byte. In IDLE both bits read 1 and ready reads 0.
- R3: In 16-bit stereo, a playback tick sets playback ready at left-lower. Each write to address 3 advances the sequence to left-upper, then right-lower, then right-upper. The write that follows right-upper clears ready.
- R4: The other formats use shorter orders. 16-bit mono runs left-lower then left-upper. 8-bit stereo runs left then right with upper=1. 8-bit mono is a single left/upper step.
- R5: A write to address 3 while playback ready is 0 changes no status bit.
- R6: A capture tick sets capture ready at the first position of the format. Reads of address 3 advance capture in the same order as playback, and ready is 0 after the last byte. A read while ready is 0 changes nothing.
- R7: A playback tick that arrives before the sample is complete sets the playback underrun flag and the slip bit, and restarts the sequence. A tick that arrives after a complete sample clears the underrun flag.
- R8: A capture tick that arrives before all bytes have been read sets the capture overrun flag and the slip bit. A tick that arrives after a fully read sample clears the overrun flag.
- R9: A rising DMA underflow strobe sets the interrupt bit. The bit then stays set until it is cleared.
- R10: Any write to address 2 clears the interrupt bit. Writes to other addresses leave it unchanged.
- R11: The interrupt pin equals the interrupt bit when the interrupt enable is high, and is low otherwise.
- R12: The read data output is loaded only on a read and holds between reads. Reads of addresses other than 2 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_rd | input | 1 | Host read strobe, one cycle |
| reg_rdata | output | 8 | Read data, loaded at the edge of a read |
| fmt_wide | input | 1 | 1 = 16-bit samples, 0 = 8-bit |
| fmt_stereo | input | 1 | 1 = stereo, 0 = mono |
| play_tick | input | 1 | Playback sample strobe (converter side) |
| cap_tick | input | 1 | Capture sample strobe (converter side) |
| dma_underflow | input | 1 | DMA current count underflow strobe |
| irq_en | input | 1 | Interrupt pin enable |
| irq_pin | output | 1 | Interrupt pin |
| play_underrun | output | 1 | Last playback tick found the sample incomplete |
| cap_overrun | output | 1 | Last capture tick found unread bytes |

## Verification
The assertions check the following on every cycle:
- A playback or capture tick always leaves the path ready.
- A path that is not ready keeps its status bits when no tick arrives.
- The slip bit changes only on a tick.
- An underflow strobe sets the interrupt bit, and a status write clears it.
- The pin stays low while the enable is low.
- The read data holds between reads.

The byte and channel orders for each format, and the exact underrun, overrun and restart outcomes, appear only in the bench's scenarios. The bench compares full status bytes against a bench model after directed sequences and after random mixes of ticks, data accesses and interrupt events.

// File: rtl/codec_pio_pkg.sv
package codec_pio_pkg;

    // Byte/channel position of one transfer path.
    typedef enum logic [2:0] {
        SEQ_LEFT_LO  = 3'd0,
        SEQ_LEFT_HI  = 3'd1,
        SEQ_RIGHT_LO = 3'd2,
        SEQ_RIGHT_HI = 3'd3,
        SEQ_IDLE     = 3'd4
    } seq_state_t;

    // Status byte, bit 7 first; the order is decoded by host software.
    typedef struct packed {
        logic cap_upper;
        logic cap_left;
        logic cap_ready;
        logic slip;
        logic play_upper;
        logic play_left;
        logic play_ready;
        logic irq;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

endpackage

// File: rtl/codec_pio_sync.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module codec_pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/codec_pio_seq.sv
// Byte/channel sequencer for one programmed-I/O path.
module codec_pio_seq
    import codec_pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_wide,
    input  logic fmt_stereo,
    input  logic tick,
    input  logic step,
    output logic ready,
    output logic chan_left,
    output logic byte_upper,
    output logic slip
);
    seq_state_t state_q;
    seq_state_t state_d;
    seq_state_t first_st;
    logic       slip_q;

    assign first_st = fmt_wide ? SEQ_LEFT_LO : SEQ_LEFT_HI;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tick) begin
                slip_q <= (state_q != SEQ_IDLE);
            end
        end
    end

    // Transitions: a tick restarts the sample, a data access steps it.
    always_comb begin
        state_d = state_q;
        if (tick) begin
            state_d = first_st;
        end else if (step) begin
            unique case (state_q)
                SEQ_LEFT_LO:  state_d = SEQ_LEFT_HI;
                SEQ_LEFT_HI:  state_d = !fmt_stereo ? SEQ_IDLE :
                                        (fmt_wide ? SEQ_RIGHT_LO : SEQ_RIGHT_HI);
                SEQ_RIGHT_LO: state_d = SEQ_RIGHT_HI;
                SEQ_RIGHT_HI: state_d = SEQ_IDLE;
                SEQ_IDLE:     state_d = SEQ_IDLE;
                default:      state_d = SEQ_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        ready      = 1'b1;
        chan_left  = 1'b1;
        byte_upper = 1'b1;
        unique case (state_q)
            SEQ_LEFT_LO:  begin chan_left = 1'b1; byte_upper = 1'b0; end
            SEQ_LEFT_HI:  begin chan_left = 1'b1; byte_upper = 1'b1; end
            SEQ_RIGHT_LO: begin chan_left = 1'b0; byte_upper = 1'b0; end
            SEQ_RIGHT_HI: begin chan_left = 1'b0; byte_upper = 1'b1; end
            SEQ_IDLE:     begin ready = 1'b0; end
            default:      begin ready = 1'b0; end
        endcase
    end

    assign slip = slip_q;

endmodule

// File: rtl/codec_pio_irq.sv
// Sticky interrupt bit with pin gating; a set wins over a same-cycle clear.
module codec_pio_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic pin
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign pin  = flag_q & en;

endmodule

// File: rtl/codec_pio_status.sv
module codec_pio_status
    import codec_pio_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int STATUS_ADDR = 2,
    parameter int DATA_ADDR   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    output logic [STATUS_W-1:0] reg_rdata,
    input  logic                fmt_wide,
    input  logic                fmt_stereo,
    input  logic                play_tick,
    input  logic                cap_tick,
    input  logic                dma_underflow,
    input  logic                irq_en,
    output logic                irq_pin,
    output logic                play_underrun,
    output logic                cap_overrun
);
    localparam int NUM_EVT = 3;
    localparam int EVT_PLAY = 0;
    localparam int EVT_CAP  = 1;
    localparam int EVT_DMA  = 2;

    logic [NUM_EVT-1:0] evt_raw;
    logic [NUM_EVT-1:0] evt_rise;
    logic               play_evt;
    logic               cap_evt;
    logic               dma_evt;

    assign evt_raw[EVT_PLAY] = play_tick;
    assign evt_raw[EVT_CAP]  = cap_tick;
    assign evt_raw[EVT_DMA]  = dma_underflow;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_sync
        codec_pio_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (evt_raw[g]),
            .rise (evt_rise[g])
        );
    end

    assign play_evt = evt_rise[EVT_PLAY];
    assign cap_evt  = evt_rise[EVT_CAP];
    assign dma_evt  = evt_rise[EVT_DMA];

    logic hit_status;
    logic hit_data;
    assign hit_status = (reg_addr == ADDR_W'(STATUS_ADDR));
    assign hit_data   = (reg_addr == ADDR_W'(DATA_ADDR));

    status_t status_s;
    logic [STATUS_W-1:0] status_w;

    codec_pio_seq i_play (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_wide  (fmt_wide),
        .fmt_stereo(fmt_stereo),
        .tick      (play_evt),
        .step      (reg_wr & hit_data),
        .ready     (status_s.play_ready),
        .chan_left (status_s.play_left),
        .byte_upper(status_s.play_upper),
        .slip      (play_underrun)
    );

    codec_pio_seq i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_wide  (fmt_wide),
        .fmt_stereo(fmt_stereo),
        .tick      (cap_evt),
        .step      (reg_rd & hit_data),
        .ready     (status_s.cap_ready),
        .chan_left (status_s.cap_left),
        .byte_upper(status_s.cap_upper),
        .slip      (cap_overrun)
    );

    codec_pio_irq i_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (dma_evt),
        .clr  (reg_wr & hit_status),
        .en   (irq_en),
        .flag (status_s.irq),
        .pin  (irq_pin)
    );

    assign status_s.slip = play_underrun | cap_overrun;
    assign status_w      = status_s;

    // The status byte is sampled once, at the edge of the read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= hit_status ? status_w : '0;
        end
    end

endmodule

// File: rtl/codec_pio_status_chk.sv
module codec_pio_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic       irq_en,
    input logic       irq_pin,
    input logic [7:0] status_w,
    input logic       play_evt,
    input logic       cap_evt,
    input logic       dma_evt
);
    p_play_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        play_evt |=> status_w[1]);

    p_play_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_w[1] && !play_evt) |=> $stable(status_w[3:1]));

    p_cap_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> status_w[5]);

    p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_w[5] && !cap_evt) |=> $stable(status_w[7:5]));

    p_slip_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_evt && !cap_evt) |=> $stable(status_w[4]));

    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_evt |=> status_w[0]);

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && !dma_evt) |=> !status_w[0]);

    p_pin_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_pin);

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind codec_pio_status codec_pio_status_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata),
    .irq_en   (irq_en),
    .irq_pin  (irq_pin),
    .status_w (status_w),
    .play_evt (play_evt),
    .cap_evt  (cap_evt),
    .dma_evt  (dma_evt)
);

// File: tb/test_codec_pio_status.sv
`timescale 1ns/1ps
module test_codec_pio_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       fmt_wide = 1'b1;
    logic       fmt_stereo = 1'b1;
    logic       play_tick = 1'b0;
    logic       cap_tick = 1'b0;
    logic       dma_underflow = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_pin;
    logic       play_underrun;
    logic       cap_overrun;

    always #2.5 clk = ~clk;

    codec_pio_status i_codec_pio_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .fmt_wide     (fmt_wide),
        .fmt_stereo   (fmt_stereo),
        .play_tick    (play_tick),
        .cap_tick     (cap_tick),
        .dma_underflow(dma_underflow),
        .irq_en       (irq_en),
        .irq_pin      (irq_pin),
        .play_underrun(play_underrun),
        .cap_overrun  (cap_overrun)
    );

    int total = 0;
    int bad = 0;

    // Bench model: position index per path, 4 = nothing pending.
    int   p_idx = 4;
    int   c_idx = 4;
    bit   p_miss = 0;
    bit   c_miss = 0;
    bit   int_f = 0;
    logic [7:0] last_rd = 8'h00;

    function automatic int seq_len();
        return (fmt_wide ? 2 : 1) * (fmt_stereo ? 2 : 1);
    endfunction

    // {upper, left, ready} for a position index
    function automatic logic [2:0] pos_bits(int idx);
        logic up, left;
        if (idx >= seq_len()) return 3'b110;
        left = ((idx / (fmt_wide ? 2 : 1)) == 0);
        up   = fmt_wide ? (idx % 2 == 1) : 1'b1;
        return {up, left, 1'b1};
    endfunction

    function automatic logic [7:0] exp_status();
        return {pos_bits(c_idx), p_miss | c_miss, pos_bits(p_idx), int_f};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [1:0] a);
        @(negedge clk);
        reg_addr = a;
        reg_wr   = 1'b1;
        @(negedge clk);
        reg_wr   = 1'b0;
    endtask

    task automatic do_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: play_tick = 1'b1;
            1: cap_tick = 1'b1;
            default: dma_underflow = 1'b1;
        endcase
        repeat (3) @(negedge clk);
        play_tick = 1'b0;
        cap_tick = 1'b0;
        dma_underflow = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic play_write();
        do_write(2'd3);
        if (p_idx < seq_len()) p_idx++;
    endtask

    task automatic cap_read(string req);
        logic [7:0] d;
        do_read(2'd3, d);
        last_rd = 8'h00;
        check(req, d, 8'h00);
        if (c_idx < seq_len()) c_idx++;
    endtask

    task automatic play_tick_op();
        pulse(0);
        p_miss = (p_idx < seq_len());
        p_idx = 0;
    endtask

    task automatic cap_tick_op();
        pulse(1);
        c_miss = (c_idx < seq_len());
        c_idx = 0;
    endtask

    task automatic check_status(string req);
        logic [7:0] d;
        do_read(2'd2, d);
        last_rd = d;
        check(req, d, exp_status());
        check(req, {7'd0, irq_pin}, {7'd0, irq_en & int_f});
        check(req, {6'd0, play_underrun, cap_overrun}, {6'd0, p_miss, c_miss});
    endtask

    task automatic set_format(bit w, bit s);
        fmt_wide = w;
        fmt_stereo = s;
        p_idx = 4;
        c_idx = 4;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset value
        do_read(2'd2, d);
        last_rd = d;
        check("R1", d, 8'hCC);
        check("R1", {7'd0, irq_pin}, 8'h00);

        // R2/R3: 16-bit stereo playback, left-lower first reads 0xC6
        play_tick_op();
        do_read(2'd2, d);
        check("R2", d, 8'hC6);
        for (int i = 0; i < 4; i++) begin
            play_write();
            check_status("R3");
        end
        // R5: write while not ready
        play_write();
        check_status("R5");
        play_write();
        check_status("R5");

        // R6: capture order and extra read
        cap_tick_op();
        check_status("R6");
        for (int i = 0; i < 5; i++) begin
            cap_read("R6");
            check_status("R6");
        end

        // R7: underrun, then recovery
        play_tick_op();
        play_write();
        play_tick_op();
        check_status("R7");
        check("R7", {7'd0, play_underrun}, 8'h01);
        for (int i = 0; i < 4; i++) play_write();
        play_tick_op();
        check_status("R7");
        check("R7", {7'd0, play_underrun}, 8'h00);

        // R8: overrun, then recovery
        cap_tick_op();
        cap_read("R8");
        cap_tick_op();
        check_status("R8");
        check("R8", {7'd0, cap_overrun}, 8'h01);
        for (int i = 0; i < 4; i++) cap_read("R8");
        cap_tick_op();
        check_status("R8");
        check("R8", {7'd0, cap_overrun}, 8'h00);

        // R9/R11: interrupt with pin gated off, then on
        irq_en = 1'b0;
        pulse(2);
        int_f = 1;
        check_status("R9");
        irq_en = 1'b1;
        @(negedge clk);
        check("R11", {7'd0, irq_pin}, 8'h01);
        // R10: other address keeps it, status write clears it
        do_write(2'd0);
        check_status("R10");
        do_write(2'd2);
        int_f = 0;
        check_status("R10");

        // R12: other address reads zero; data held without a read
        do_read(2'd1, d);
        check("R12", d, 8'h00);
        last_rd = d;
        check_status("R12");
        play_tick_op();
        do_write(2'd0);
        check("R12", reg_rdata, last_rd);

        // R4: remaining formats, both paths
        for (int f = 0; f < 3; f++) begin
            play_tick_op();
            cap_tick_op();
            for (int i = 0; i < 4; i++) begin
                play_write();
                cap_read("R4");
            end
            set_format(f == 0, f != 0 ? (f == 1) : 1'b0);
            play_tick_op();
            cap_tick_op();
            check_status("R4");
            for (int i = 0; i < 3; i++) begin
                play_write();
                cap_read("R4");
                check_status("R4");
            end
        end

        // Random mix checked against the model (R2)
        for (int n = 0; n < 400; n++) begin
            case ($urandom_range(0, 9))
                0, 1: play_write();
                2, 3: cap_read("R6");
                4:    play_tick_op();
                5:    cap_tick_op();
                6:    begin pulse(2); int_f = 1; end
                7:    begin do_write(2'd2); int_f = 0; end
                8:    irq_en = $urandom_range(0, 1) != 0;
                default: begin
                    if (p_idx >= seq_len() && c_idx >= seq_len())
                        set_format($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0);
                end
            endcase
            check_status("R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule